// File: doc/BRIEF.md
# Standby and Reset Controller

This block sequences the low-power modes and the internal reset of a small 8-bit microcontroller. Software writes a single control register on the peripheral bus. One bit asks for a light sleep, where only the CPU clock is gated. Another asks for a deep stop, where the oscillator and every clock are halted. A third picks how the pins behave while stopped, and a fourth fires a short software reset. Four reset causes are merged into one internal reset output: power-on through `rst_ni`, a low level on the external reset pin, a watchdog overflow and the software bit.

Whenever the oscillator has been off, operation resumes only after a settling wait. This covers power-on, a wake-up from stop and, when the power-on option is set, a reset taken while stopped. The wait is counted in pulses of `tick_i`, which stands in for the timebase. Each pulse represents 2^12 oscillator cycles, so the long and short default limits of 64 and 4 pulses correspond to 2^18 and 2^14 oscillator cycles. The external reset pin and the watchdog flag are assumed to be already synchronous to `clk_i`. The clock, oscillator, pin and reset controls are driven straight from flops.

Top module: `standby_reset_ctrl`

## Requirements
- R1: While `rst_ni` is low and just after it rises, `rst_o`=1, `osc_en_o`=1, `cpu_clk_en_o`=0, `per_clk_en_o`=0, `pin_hiz_o`=0, and `rd_data_o` reads 8'h10.
- R2: After power-on the controller counts only cycles in which `tick_i` is high. `rst_o` falls and both clock enables rise on the edge that samples the WAIT-th pulse. WAIT is 64 by default and 4 when `USE_SHORT_WAIT`=1.
- R3: Read value layout: bits 7 and 6 always read 0, bit 4 always reads 1, bits 3..0 read 0, and bit 5 returns the last pin-select value written.
- R4: A write with bit 4 = 0 drives `rst_o` high for exactly 4 cycles starting at the write edge, and it clears the pin-select bit. The mode bits of that same write are ignored, and the CPU clock stays on. A write with bit 4 = 1 fires no reset.
- R5: A write of bit 7 or bit 6 while `irq_pend_i` is high enters no mode, and the clocks stay on.
- R6: Writing bit 6 = 1 (with bit 7 = 0) enters sleep on the write edge: the CPU clock turns off while the peripheral clock and the oscillator stay on. Sleep ends when `irq_pend_i` is sampled high or when an external or watchdog reset arrives.
- R7: Writing bit 7 = 1 enters stop, and it takes priority over bit 6. The oscillator and both clocks turn off. `irq_pend_i` does not end stop; only `ext_irq_i` or a reset does.
- R8: `pin_hiz_o` is high only while stopped and only if the pin-select bit (bit 5) was 1. Otherwise the pins hold their levels.
- R9: A wake-up from stop by `ext_irq_i` turns the oscillator on with both clocks off and no reset. It runs after WAIT further tick pulses, and the pin-select bit is kept.
- R10: An external reset in stop, with `POR_OPTION`=1, asserts `rst_o` and waits WAIT ticks before running. With `POR_OPTION`=0 it returns to run at once, and `rst_o` follows the pin.
- R11: An external pin low or a watchdog overflow, sampled in run or sleep, sets `rst_o` on that edge. `rst_o` stays high while the cause is present, the CPU clock stays on, and `rst_o` falls on the edge after the cause clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_ni | input | 1 | External reset pin, active low, synchronous |
| wdog_ovf_i | input | 1 | Watchdog overflow |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Control register read value |
| irq_pend_i | input | 1 | Enabled interrupt above lowest level pending |
| ext_irq_i | input | 1 | External interrupt request |
| tick_i | input | 1 | Timebase settle tick, one cycle wide |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| pin_hiz_o | output | 1 | Tri-state pins while stopped |
| rst_o | output | 1 | Merged internal reset, active high |

## Verification
The hardest case to reach is a reset that arrives while the block is stopped, because the two power-on option settings then part ways. The bench drives one stimulus into two instances, one with the option set and one with it cleared. It parks both in stop, pulls the external pin low for three cycles, and checks cycle by cycle that one instance holds reset through the full settle count while the other runs as soon as the pin releases. Irregular tick spacing during the power-on wait shows that only tick pulses are counted. A random phase then mixes write values with pending interrupts against a bench prediction of the next mode.

// File: rtl/stbc_pkg.sv
package stbc_pkg;
  typedef enum logic [1:0] {
    MODE_SETTLE = 2'd0,
    MODE_RUN    = 2'd1,
    MODE_SLEEP  = 2'd2,
    MODE_STOP   = 2'd3
  } mode_e;

  localparam int unsigned BIT_STOP   = 7;
  localparam int unsigned BIT_SLEEP  = 6;
  localparam int unsigned BIT_PINSEL = 5;
  localparam int unsigned BIT_SWRST  = 4;
endpackage

// File: rtl/stbc_ctrl_reg.sv
module stbc_ctrl_reg
  import stbc_pkg::*;
#(
  parameter int unsigned SW_RST_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_ok_i,
  input  logic [7:0] wr_data_i,
  input  logic       clr_i,
  output logic       stop_req_o,
  output logic       sleep_req_o,
  output logic       sw_rst_nxt_o,
  output logic       pin_sel_o,
  output logic [7:0] rd_data_o
);
  localparam int unsigned CW = $clog2(SW_RST_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pin_sel_q;
  logic          sw_fire, keep_bit;
  logic          unused_low;

  assign unused_low = ^wr_data_i[3:0];
  assign keep_bit   = wr_data_i[BIT_SWRST];
  assign sw_fire    = wr_ok_i & ~keep_bit;
  // a software reset write cancels any mode request in it
  assign stop_req_o  = wr_ok_i & keep_bit & wr_data_i[BIT_STOP];
  assign sleep_req_o = wr_ok_i & keep_bit & wr_data_i[BIT_SLEEP];

  always_comb begin
    if (sw_fire)           cnt_d = CW'(SW_RST_CYCLES);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = '0;
  end
  assign sw_rst_nxt_o = (cnt_d != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      pin_sel_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (clr_i)                   pin_sel_q <= 1'b0;
      else if (wr_ok_i && keep_bit) pin_sel_q <= wr_data_i[BIT_PINSEL];
    end
  end

  assign pin_sel_o = pin_sel_q;
  assign rd_data_o = {2'b00, pin_sel_q, 1'b1, 4'b0000};

  assert_sw_pulse_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cnt_q != '0) |-> $past(wr_ok_i && !wr_data_i[BIT_SWRST]));
  assert_pinsel_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !pin_sel_q);
endmodule

// File: rtl/stbc_settle_cnt.sv
module stbc_settle_cnt #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == CW'(LIMIT - 1));
  assign done_o = run_i & tick_i & at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (tick_i)      cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end

  assert_tick_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/standby_reset_ctrl.sv
module standby_reset_ctrl
  import stbc_pkg::*;
#(
  parameter int unsigned LONG_WAIT_TICKS  = 64,
  parameter int unsigned SHORT_WAIT_TICKS = 4,
  parameter bit          USE_SHORT_WAIT   = 1'b0,
  parameter bit          POR_OPTION       = 1'b1,
  parameter int unsigned SW_RST_CYCLES    = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_rst_ni,
  input  logic       wdog_ovf_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  input  logic       irq_pend_i,
  input  logic       ext_irq_i,
  input  logic       tick_i,
  output logic       cpu_clk_en_o,
  output logic       per_clk_en_o,
  output logic       osc_en_o,
  output logic       pin_hiz_o,
  output logic       rst_o
);
  localparam int unsigned WAIT_TICKS = USE_SHORT_WAIT ? SHORT_WAIT_TICKS : LONG_WAIT_TICKS;

  mode_e mode_q, mode_d;
  logic  hold_q, hold_d;
  logic  rst_q, cpu_en_q, per_en_q, osc_en_q;
  logic  hw_rst, wr_ok, stop_req, sleep_req, sw_rst_nxt, pin_sel, settle_done;

  assign hw_rst = ~ext_rst_ni | wdog_ovf_i;
  assign wr_ok  = wr_en_i & (mode_q == MODE_RUN) & ~rst_q & ~hw_rst;

  stbc_ctrl_reg #(.SW_RST_CYCLES(SW_RST_CYCLES)) u_reg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_ok_i      (wr_ok),
    .wr_data_i    (wr_data_i),
    .clr_i        (rst_q),
    .stop_req_o   (stop_req),
    .sleep_req_o  (sleep_req),
    .sw_rst_nxt_o (sw_rst_nxt),
    .pin_sel_o    (pin_sel),
    .rd_data_o    (rd_data_o)
  );

  stbc_settle_cnt #(.LIMIT(WAIT_TICKS)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (mode_q == MODE_SETTLE),
    .tick_i (tick_i),
    .done_o (settle_done)
  );

  always_comb begin
    mode_d = mode_q;
    hold_d = hold_q;
    unique case (mode_q)
      MODE_SETTLE: begin
        if (hw_rst) hold_d = 1'b1;
        if (settle_done) begin
          mode_d = MODE_RUN;
          hold_d = 1'b0;
        end
      end
      MODE_RUN: begin
        if (!irq_pend_i) begin
          if (stop_req)       mode_d = MODE_STOP;
          else if (sleep_req) mode_d = MODE_SLEEP;
        end
      end
      MODE_SLEEP: begin
        if (hw_rst || irq_pend_i) mode_d = MODE_RUN;
      end
      MODE_STOP: begin
        if (hw_rst) begin
          if (POR_OPTION) begin
            mode_d = MODE_SETTLE;
            hold_d = 1'b1;
          end else begin
            mode_d = MODE_RUN;
          end
        end else if (ext_irq_i) begin
          mode_d = MODE_SETTLE;
          hold_d = 1'b0;
        end
      end
      default: mode_d = MODE_SETTLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_SETTLE;
      hold_q   <= 1'b1;
      rst_q    <= 1'b1;
      cpu_en_q <= 1'b0;
      per_en_q <= 1'b0;
      osc_en_q <= 1'b1;
    end else begin
      mode_q   <= mode_d;
      hold_q   <= hold_d;
      rst_q    <= hw_rst | hold_d | sw_rst_nxt;
      cpu_en_q <= (mode_d == MODE_RUN);
      per_en_q <= (mode_d == MODE_RUN) || (mode_d == MODE_SLEEP);
      osc_en_q <= (mode_d != MODE_STOP);
    end
  end

  assign cpu_clk_en_o = cpu_en_q;
  assign per_clk_en_o = per_en_q;
  assign osc_en_o     = osc_en_q;
  assign pin_hiz_o    = ~osc_en_q & pin_sel;
  assign rst_o        = rst_q;

  assert_clk_nesting_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_en_q |-> per_en_q);
  assert_sleep_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SLEEP && irq_pend_i) |=> cpu_en_q);
  assert_mode_blocked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RUN && wr_en_i && irq_pend_i) |=> (mode_q == MODE_RUN && osc_en_q));
  assert_stop_stays_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STOP && !hw_rst && !ext_irq_i) |=> (!osc_en_q && !per_en_q));
  assert_hw_rst_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_rst |=> rst_q);
endmodule

// File: tb/standby_reset_ctrl_bench.sv
`timescale 1ns/1ps
module standby_reset_ctrl_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, ext_rst_n, wdog, wr_en, irq_pend, ext_irq, tick;
  logic [7:0] wr_data;
  logic [7:0] rd_m, rd_n;
  logic cpu_m, per_m, osc_m, hiz_m, rst_m;
  logic cpu_n, per_n, osc_n, hiz_n, rst_n_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  standby_reset_ctrl u_standby_reset_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ext_rst_ni(ext_rst_n), .wdog_ovf_i(wdog),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_m),
    .irq_pend_i(irq_pend), .ext_irq_i(ext_irq), .tick_i(tick),
    .cpu_clk_en_o(cpu_m), .per_clk_en_o(per_m), .osc_en_o(osc_m),
    .pin_hiz_o(hiz_m), .rst_o(rst_m));

  standby_reset_ctrl #(.USE_SHORT_WAIT(1'b1), .POR_OPTION(1'b0)) u_nopor (
    .clk_i(clk), .rst_ni(rst_n), .ext_rst_ni(ext_rst_n), .wdog_ovf_i(wdog),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_n),
    .irq_pend_i(irq_pend), .ext_irq_i(ext_irq), .tick_i(tick),
    .cpu_clk_en_o(cpu_n), .per_clk_en_o(per_n), .osc_en_o(osc_n),
    .pin_hiz_o(hiz_n), .rst_o(rst_n_o));

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk1(string tag, logic act, logic exp);
    chk(tag, {7'd0, act}, {7'd0, exp});
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d, logic ip);
    wr_en = 1'b1; wr_data = d; irq_pend = ip;
    nxt();
    wr_en = 1'b0; irq_pend = 1'b0;
  endtask

  // 0 run, 1 sleep, 2 stop, 3 software reset
  function automatic int pred_mode(logic [7:0] d, logic ip);
    if (!d[4]) return 3;
    if (ip)    return 0;
    if (d[7])  return 2;
    if (d[6])  return 1;
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired act=running exp=done");
      summary();
      $finish;
    end
  end

  initial begin
    int ticks;
    logic exp_pin;
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; ext_rst_n = 1'b1; wdog = 1'b0; wr_en = 1'b0; wr_data = '0;
    irq_pend = 1'b0; ext_irq = 1'b0; tick = 1'b0;
    repeat (3) nxt();
    chk1("R1 rst", rst_m, 1'b1);  chk1("R1 osc", osc_m, 1'b1);
    chk1("R1 cpu", cpu_m, 1'b0);  chk1("R1 per", per_m, 1'b0);
    chk1("R1 hiz", hiz_m, 1'b0);  chk("R1 rd", rd_m, 8'h10);
    chk1("R1 rst nopor", rst_n_o, 1'b1); chk("R1 rd nopor", rd_n, 8'h10);
    rst_n = 1'b1;
    nxt();
    chk1("R1 rst after release", rst_m, 1'b1);

    // R2: irregular ticks, only pulses counted
    ticks = 0;
    for (int i = 0; i < 400 && ticks < 66; i++) begin
      tick = (i % 3 == 0);
      nxt();
      if (tick) ticks++;
      chk1("R2 cpu", cpu_m, ticks >= 64);
      chk1("R2 rst", rst_m, ticks < 64);
      chk1("R2 cpu short", cpu_n, ticks >= 4);
    end
    tick = 1'b1;
    chk1("R2 per", per_m, 1'b1);

    // R3 readback
    wr(8'h30, 1'b0); chk("R3 rd pinsel", rd_m, 8'h30);
    wr(8'hFF & 8'h3F, 1'b0); chk("R3 rd bits", rd_m, 8'h30);
    wr(8'h10, 1'b0); chk("R3 rd clear", rd_m, 8'h10);
    chk1("R4 bit4 one no reset", rst_m, 1'b0);

    // R4 software reset, mode bits ignored
    wr(8'h30, 1'b0);
    wr(8'hE0, 1'b0);
    for (int j = 1; j <= 5; j++) begin
      chk1("R4 pulse", rst_m, j <= 4);
      chk1("R4 cpu stays", cpu_m, 1'b1);
      chk1("R4 osc stays", osc_m, 1'b1);
      if (j < 5) nxt();
    end
    chk("R4 pinsel cleared", rd_m, 8'h10);

    // R5 pending interrupt blocks entry
    wr(8'h90, 1'b1); chk1("R5 stop blocked", osc_m, 1'b1); chk1("R5 cpu", cpu_m, 1'b1);
    wr(8'h50, 1'b1); chk1("R5 sleep blocked", cpu_m, 1'b1);

    // R6 sleep
    wr(8'h50, 1'b0);
    chk1("R6 cpu off", cpu_m, 1'b0); chk1("R6 per on", per_m, 1'b1); chk1("R6 osc", osc_m, 1'b1);
    repeat (3) nxt();
    chk1("R6 still asleep", cpu_m, 1'b0);
    irq_pend = 1'b1; nxt(); irq_pend = 1'b0;
    chk1("R6 irq wake", cpu_m, 1'b1);
    wr(8'h50, 1'b0);
    chk1("R6 asleep again", cpu_m, 1'b0);
    wdog = 1'b1; nxt(); wdog = 1'b0;
    chk1("R11 wdog rst", rst_m, 1'b1); chk1("R11 cpu on", cpu_m, 1'b1);
    nxt();
    chk1("R11 rst released", rst_m, 1'b0);
    ext_rst_n = 1'b0; nxt();
    chk1("R11 pin rst", rst_m, 1'b1); nxt();
    chk1("R11 pin held", rst_m, 1'b1); ext_rst_n = 1'b1; nxt();
    chk1("R11 pin released", rst_m, 1'b0);

    // R7/R8 stop with priority over sleep
    wr(8'hF0, 1'b0);
    chk1("R7 osc off", osc_m, 1'b0); chk1("R7 cpu off", cpu_m, 1'b0);
    chk1("R7 per off", per_m, 1'b0); chk1("R8 hiz", hiz_m, 1'b1);
    irq_pend = 1'b1; repeat (3) nxt(); irq_pend = 1'b0;
    chk1("R7 irq ignored", osc_m, 1'b0);

    // R9 wake by external interrupt
    ext_irq = 1'b1; nxt(); ext_irq = 1'b0;
    chk1("R9 osc on", osc_m, 1'b1); chk1("R9 cpu off", cpu_m, 1'b0);
    chk1("R9 no rst", rst_m, 1'b0); chk1("R8 hiz off", hiz_m, 1'b0);
    for (int j = 1; j <= 65; j++) begin
      nxt();
      chk1("R9 settle", cpu_m, j >= 64);
      chk1("R9 settle short", cpu_n, j >= 4);
      chk1("R9 no rst", rst_m, 1'b0);
    end
    chk("R9 pinsel kept", rd_m, 8'h30);

    // R10 external reset in stop
    wr(8'h90, 1'b0);
    chk1("R8 hold pins", hiz_m, 1'b0); chk1("R10 stopped", osc_n, 1'b0);
    ext_rst_n = 1'b0;
    for (int j = 0; j <= 65; j++) begin
      nxt();
      if (j == 2) ext_rst_n = 1'b1;
      chk1("R10 por rst", rst_m, j < 64);
      chk1("R10 por cpu", cpu_m, j >= 64);
      chk1("R10 nopor rst", rst_n_o, j <= 2);
      chk1("R10 nopor cpu", cpu_n, 1'b1);
    end
    chk("R10 rd", rd_m, 8'h10);

    // random phase
    exp_pin = 1'b0;
    for (int it = 0; it < 150; it++) begin
      logic [7:0] d;
      logic ip;
      int   m;
      d  = 8'($urandom);
      ip = ($urandom % 4) == 0;
      m  = pred_mode(d, ip);
      wr(d, ip);
      case (m)
        3: begin
          chk1("R4 rnd rst", rst_m, 1'b1); chk1("R4 rnd cpu", cpu_m, 1'b1);
          repeat (5) nxt();
          exp_pin = 1'b0;
        end
        2: begin
          chk1("R7 rnd osc", osc_m, 1'b0); chk1("R8 rnd hiz", hiz_m, d[5]);
          exp_pin = d[5];
          ext_irq = 1'b1; nxt(); ext_irq = 1'b0;
          repeat (70) nxt();
        end
        1: begin
          chk1("R6 rnd cpu", cpu_m, 1'b0); chk1("R6 rnd per", per_m, 1'b1);
          exp_pin = d[5];
          irq_pend = 1'b1; nxt(); irq_pend = 1'b0;
        end
        default: begin
          chk1("R5 rnd stay", osc_m, 1'b1);
          exp_pin = d[5];
        end
      endcase
      chk1("R6 rnd run", cpu_m, 1'b1);
      chk1("R4 rnd rst low", rst_m, 1'b0);
      chk("R3 rnd rd", rd_m, {2'b00, exp_pin, 1'b1, 4'b0000});
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule